// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to 32 hardware interrupt sources behind a small word-addressed register window. Each source has the same bit index in every register. A one-cycle event pulse on a source is held in a cause register until software clears it. Software picks, bit by bit, how each held cause is cleared: either by writing a one to it, or as a side effect of reading it.

A mask register hides selected causes from the interrupt line. The mask can be written whole or changed through separate set-only and clear-only aliases, so no read-modify-write is needed. A masked view of the cause register can be read and cleared in the same way as the raw cause register. The single interrupt output is the registered OR of all unmasked causes.

Top module: `icr_bank`

## Requirements
- R1: After reset the cause, clear-mode and mask registers are all zero, `irqOut` is 0 and `regRdata` is 0.
- R2: Registers sit at these byte offsets: 0x00 clear-mode, 0x04 cause, 0x08 masked cause, 0x0C cause-set, 0x10 mask, 0x14 mask-set, 0x18 mask-clear. Address bits [1:0] are ignored. Offset 0x1C reads zero and ignores writes. Bit i refers to source i in every register.
- R3: Read data appears on `regRdata` in the cycle after `regRd` is sampled high. In every other cycle `regRdata` is zero.
- R4: A `hwEvent` bit that is high at a clock edge sets its cause bit, which stays set until it is cleared. An event in the same cycle as any clear of that bit wins, and the bit stays set.
- R5: When a clear-mode bit is 0, writing 1 to that cause bit clears it. Writing 0 has no effect. A cause write to a bit whose clear-mode bit is 1 is ignored.
- R6: When a clear-mode bit is 1, reading the cause register returns that bit and then clears it. Bits whose clear-mode bit is 0 are never changed by a read.
- R7: The masked-cause register reads as cause AND NOT mask.
- R8: A write of 1 to the masked-cause register clears only those cause bits that are unmasked and have clear-mode 0. A read of it clears only the bits it returned as 1 that have clear-mode 1.
- R9: Writing 1 to a cause-set bit sets that cause bit. The cause-set register reads zero.
- R10: Writing 1 to a mask-set bit sets that mask bit, and writing 1 to a mask-clear bit clears it. Zeros have no effect. Both aliases read zero.
- R11: The mask register can be written directly and reads back its value.
- R12: `irqOut` is high exactly when some cause bit was unmasked at the previous clock edge. It lags the cause and mask state by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Byte address of the register access |
| regWr | input | 1 | Write strobe for one cycle |
| regWdata | input | 32 | Write data |
| regRd | input | 1 | Read strobe for one cycle |
| hwEvent | input | 32 | Hardware event pulses, one bit per source |
| regRdata | output | 32 | Registered read data, zero when no read is in progress |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `regRd` and `regWr` are never high in the same cycle. They also assume that a write to the mask-set or cause-set alias is not paired with a competing write, which a single-port register bus ensures. The stimulus drives every access on the falling clock edge for exactly one cycle and never overlaps a read with a write. Events that collide with a clear are made deliberately, by raising `hwEvent` in the same cycle as the clearing write or read.

// File: rtl/icr_pkg.sv
package icr_pkg;

  localparam int SEL_W    = 3;
  localparam int WORD_LSB = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_SET    = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_MSET   = 3'd5,
    SEL_MCLR   = 3'd6,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrCause;
    logic    wrMasked;
    logic    wrSet;
    logic    wrMask;
    logic    wrMaskSet;
    logic    wrMaskClr;
    logic    rdCause;
    logic    rdMasked;
    logic    rdAny;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/icr_ctrl.sv
module icr_ctrl
  import icr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output strobe_t           strb
);

  localparam int HI_LSB = WORD_LSB + SEL_W;

  logic             upperZero;
  logic [SEL_W-1:0] wordIdx;
  regSel_e          sel;
  logic             wrEn;
  logic             rdEn;
  logic             unusedLowBits;

  // byte lanes are not decoded
  assign unusedLowBits = ^regAddr[WORD_LSB-1:0];

  generate
    if (ADDR_W > HI_LSB) begin : g_hiDecode
      assign upperZero = (regAddr[ADDR_W-1:HI_LSB] == '0);
    end else begin : g_noHi
      assign upperZero = 1'b1;
    end
  endgenerate

  assign wordIdx = regAddr[WORD_LSB +: SEL_W];
  assign sel     = regSel_e'(wordIdx);
  assign wrEn    = regWr & upperZero;
  assign rdEn    = regRd & upperZero;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (wrEn) begin
      case (sel)
        SEL_CTRL:   strb.wrCtrl    = 1'b1;
        SEL_CAUSE:  strb.wrCause   = 1'b1;
        SEL_MASKED: strb.wrMasked  = 1'b1;
        SEL_SET:    strb.wrSet     = 1'b1;
        SEL_MASK:   strb.wrMask    = 1'b1;
        SEL_MSET:   strb.wrMaskSet = 1'b1;
        SEL_MCLR:   strb.wrMaskClr = 1'b1;
        default:    ;
      endcase
    end
    if (rdEn) begin
      strb.rdAny    = 1'b1;
      strb.rdSel    = sel;
      strb.rdCause  = (sel == SEL_CAUSE);
      strb.rdMasked = (sel == SEL_MASKED);
    end
  end

endmodule

// File: rtl/icr_datapath.sv
module icr_datapath
  import icr_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [NUM_SRC-1:0] regWdata,
  input  logic [NUM_SRC-1:0] hwEvent,
  output logic [NUM_SRC-1:0] regRdata,
  output logic [NUM_SRC-1:0] causeQ,
  output logic [NUM_SRC-1:0] maskQ
);

  logic [NUM_SRC-1:0] ctrlQ;
  logic [NUM_SRC-1:0] maskedView;
  logic [NUM_SRC-1:0] w1cClr;
  logic [NUM_SRC-1:0] corClr;
  logic [NUM_SRC-1:0] setBits;
  logic [NUM_SRC-1:0] causeNext;
  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] rdMux;

  assign maskedView = causeQ & ~maskQ;

  always_comb begin
    w1cClr = '0;
    if (strb.wrCause)  w1cClr = w1cClr | (regWdata & ~ctrlQ);
    if (strb.wrMasked) w1cClr = w1cClr | (regWdata & ~ctrlQ & ~maskQ);
  end

  always_comb begin
    corClr = '0;
    if (strb.rdCause)  corClr = corClr | (causeQ & ctrlQ);
    if (strb.rdMasked) corClr = corClr | (maskedView & ctrlQ);
  end

  assign setBits   = strb.wrSet ? regWdata : '0;
  // a new event outranks any clear in the same cycle
  assign causeNext = (causeQ & ~(w1cClr | corClr)) | setBits | hwEvent;

  always_comb begin
    if (strb.wrMask) begin
      maskNext = regWdata;
    end else begin
      maskNext = maskQ;
      if (strb.wrMaskSet) maskNext = maskNext | regWdata;
      if (strb.wrMaskClr) maskNext = maskNext & ~regWdata;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CTRL:   rdMux = ctrlQ;
      SEL_CAUSE:  rdMux = causeQ;
      SEL_MASKED: rdMux = maskedView;
      SEL_MASK:   rdMux = maskQ;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ    <= '0;
      causeQ   <= '0;
      maskQ    <= '0;
      regRdata <= '0;
    end else begin
      if (strb.wrCtrl) ctrlQ <= regWdata;
      causeQ   <= causeNext;
      maskQ    <= maskNext;
      regRdata <= strb.rdAny ? rdMux : '0;
    end
  end

endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [NUM_SRC-1:0] regWdata,
  input  logic               regRd,
  input  logic [NUM_SRC-1:0] hwEvent,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               irqOut
);

  strobe_t            strb;
  logic [NUM_SRC-1:0] causeQ;
  logic [NUM_SRC-1:0] maskQ;

  icr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strb    (strb)
  );

  icr_datapath #(.NUM_SRC(NUM_SRC)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .regWdata (regWdata),
    .hwEvent  (hwEvent),
    .regRdata (regRdata),
    .causeQ   (causeQ),
    .maskQ    (maskQ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= |(causeQ & ~maskQ);
  end

endmodule

// File: rtl/icr_bank_chk.sv
module icr_bank_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWr,
  input logic [NUM_SRC-1:0] regWdata,
  input logic               regRd,
  input logic [NUM_SRC-1:0] hwEvent,
  input logic [NUM_SRC-1:0] regRdata,
  input logic [NUM_SRC-1:0] causeQ,
  input logic [NUM_SRC-1:0] maskQ
);

  logic [ADDR_W-1:0] word;
  assign word = regAddr >> 2;

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwEvent != '0) |=> ((causeQ & $past(hwEvent)) == $past(hwEvent)));

  // R9
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && word == ADDR_W'(3)) |=> ((causeQ & $past(regWdata)) == $past(regWdata)));

  // R10
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && word == ADDR_W'(5)) |=> ((maskQ & $past(regWdata)) == $past(regWdata)));

  // R10
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && word == ADDR_W'(6)) |=> ((maskQ & $past(regWdata)) == '0));

  // R9
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regRd && (word == ADDR_W'(3) || word == ADDR_W'(5) || word == ADDR_W'(6)))
      |=> (regRdata == '0));

  // R3
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regRd |=> (regRdata == '0));

  // R11
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && word == ADDR_W'(4)) |=> (maskQ == $past(regWdata)));

endmodule

bind icr_bank icr_bank_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .regAddr  (regAddr),
  .regWr    (regWr),
  .regWdata (regWdata),
  .regRd    (regRd),
  .hwEvent  (hwEvent),
  .regRdata (regRdata),
  .causeQ   (causeQ),
  .maskQ    (maskQ)
);

// File: tb/test_icr_bank.sv
`timescale 1ns/1ps
module test_icr_bank;

  localparam int NUM_SRC = 32;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00, A_CAUSE = 5'h04, A_MASKED = 5'h08,
    A_SET = 5'h0C, A_MASK = 5'h10, A_MSET = 5'h14, A_MCLR = 5'h18, A_HOLE = 5'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic               regWr = 1'b0;
  logic               regRd = 1'b0;
  logic [NUM_SRC-1:0] regWdata = '0;
  logic [NUM_SRC-1:0] hwEvent = '0;
  logic [NUM_SRC-1:0] regRdata;
  logic               irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 1'b0;
  logic rdPending = 1'b0;
  logic [NUM_SRC-1:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  icr_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_icr_bank (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRd(regRd), .hwEvent(hwEvent),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) rdPending <= regRd;

  always @(negedge clk) begin
    if (rdPending) begin
      checkCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL R3: unexpected read data %h expected none", regRdata);
      end else begin
        automatic logic [NUM_SRC-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (regRdata !== e) begin
          failCnt++;
          $display("FAIL %s: read data %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] e, input string t);
    regAddr = a; regRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] ev);
    hwEvent = ev;
    @(negedge clk);
    hwEvent = '0;
  endtask

  task automatic writeWithEvent(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d,
                                input logic [NUM_SRC-1:0] ev);
    hwEvent = ev;
    regWrite(a, d);
    hwEvent = '0;
  endtask

  task automatic readWithEvent(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] ev,
                               input logic [NUM_SRC-1:0] e, input string t);
    hwEvent = ev;
    regRead(a, e, t);
    hwEvent = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkIrq(input logic e, input string t);
    checkCnt++;
    if (irqOut !== e) begin
      failCnt++;
      $display("FAIL %s: irqOut %b expected %b", t, irqOut, e);
    end
  endtask

  task automatic checkIdle(input string t);
    checkCnt++;
    if (regRdata !== '0) begin
      failCnt++;
      $display("FAIL %s: idle read data %h expected %h", t, regRdata, 32'h0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: cycles %0d expected below %0d", 20000, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkIdle("R1");
    checkIrq(1'b0, "R1");
    regRead(A_CTRL, 32'h0, "R1");
    regRead(A_CAUSE, 32'h0, "R1");
    regRead(A_MASK, 32'h0, "R1");

    // R4 event latching, R6 reads leave clear-mode 0 bits alone
    pulse(32'h0000_0005);
    regRead(A_CAUSE, 32'h0000_0005, "R4");
    regRead(A_CAUSE, 32'h0000_0005, "R6");
    idle(1);
    checkIrq(1'b1, "R12");

    // R5 write-one-to-clear
    regWrite(A_CAUSE, 32'h0000_0004);
    regRead(A_CAUSE, 32'h0000_0001, "R5");
    regWrite(A_CAUSE, 32'h0000_0000);
    regRead(A_CAUSE, 32'h0000_0001, "R5");

    // R6 clear-on-read; R5 writes ignored for clear-mode 1 bits
    regWrite(A_CTRL, 32'h0000_0001);
    regRead(A_CTRL, 32'h0000_0001, "R2");
    regWrite(A_CAUSE, 32'h0000_0001);
    regRead(A_CAUSE, 32'h0000_0001, "R5");
    regRead(A_CAUSE, 32'h0000_0000, "R6");
    idle(1);
    checkIrq(1'b0, "R12");

    // R9 cause-set
    regWrite(A_SET, 32'h0000_00F0);
    regRead(A_SET, 32'h0, "R9");
    regRead(A_CAUSE, 32'h0000_00F0, "R9");

    // R11 mask, R7 masked view, R8 masked clear-on-read
    regWrite(A_MASK, 32'h0000_0030);
    regRead(A_MASK, 32'h0000_0030, "R11");
    regRead(A_MASKED, 32'h0000_00C0, "R7");
    regWrite(A_CTRL, 32'h0000_0080);
    regRead(A_MASKED, 32'h0000_00C0, "R8");
    regRead(A_CAUSE, 32'h0000_0070, "R8");

    // R8 masked write clears only unmasked clear-mode 0 bits
    regWrite(A_MASKED, 32'h0000_0070);
    regRead(A_CAUSE, 32'h0000_0030, "R8");

    // R10 mask aliases
    regWrite(A_MSET, 32'h0000_0F00);
    regRead(A_MASK, 32'h0000_0F30, "R10");
    regWrite(A_MCLR, 32'h0000_0010);
    regRead(A_MASK, 32'h0000_0F20, "R10");
    regWrite(A_MSET, 32'h0000_0000);
    regWrite(A_MCLR, 32'h0000_0000);
    regRead(A_MASK, 32'h0000_0F20, "R10");
    regRead(A_MSET, 32'h0, "R10");
    regRead(A_MCLR, 32'h0, "R10");
    idle(1);
    checkIrq(1'b1, "R12");
    regWrite(A_MSET, 32'h0000_0010);
    idle(1);
    checkIrq(1'b0, "R12");

    // R4 event beats a write-one-to-clear and a clear-on-read
    writeWithEvent(A_CAUSE, 32'h0000_0010, 32'h0000_0010);
    regRead(A_CAUSE, 32'h0000_0030, "R4");
    regWrite(A_SET, 32'h0000_0080);
    readWithEvent(A_CAUSE, 32'h0000_0080, 32'h0000_00B0, "R4");
    regRead(A_CAUSE, 32'h0000_00B0, "R4");
    regRead(A_CAUSE, 32'h0000_0030, "R6");

    // R2 byte lanes ignored, unused offset inert
    regRead(5'h12, 32'h0000_0F30, "R2");
    regWrite(A_HOLE, 32'hFFFF_FFFF);
    regRead(A_HOLE, 32'h0, "R2");
    regRead(A_CAUSE, 32'h0000_0030, "R2");
    regRead(A_CTRL, 32'h0000_0080, "R2");
    regRead(A_MASK, 32'h0000_0F30, "R2");

    // R3 read data returns to zero
    idle(1);
    checkIdle("R3");

    idle(2);
    if (expQ.size() != 0) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R3: %0d reads unanswered expected %0d", expQ.size(), 0);
    end
    doneFlag = 1'b1;
    summary();
    $finish;
  end

endmodule